// File: doc/BRIEF.md
# Key-Protected Core Control Register

This block is a single 32-bit control register that governs one subordinate processor core. A bus master writes it through an address-decoded write strobe carrying a full 32-bit word. A write changes nothing unless its upper half-word holds the unlock key 0x05FA. The register holds two control bits. One stalls debug accesses to the core. The other enables the core.

Software clears the enable bit to warm-boot the core. The block then gates the core clock, asserts the core reset and keeps both in force for a configurable minimum number of cycles. During that reset it pulses a one-cycle clear to the core's protection context. After the interval the block restores the clock, then releases the reset one cycle later, and finally sets the enable bit again without any further software action.

Top module: `core_ctl_reg`

## Requirements
- R1: After reset the read data is 0xFA05_0002 (enable bit 1 = 1, stall bit 0 = 0), the clock enable is 1, the core reset is 0 and the context clear is 0.
- R2: A write whose bits 31:16 differ from 0x05FA leaves the register and all outputs unchanged.
- R3: Bits 31:16 of the read data always return 0xFA05, and bits 15:2 always return 0, whatever was written.
- R4: A valid-key write sets the stall bit (bit 0) to the written value on the next cycle, and the debug stall output follows that bit.
- R5: A valid-key write with bit 1 = 0 drives the clock enable low and the core reset high on the next cycle. The reset stays high for at least DIS_CYCLES cycles.
- R6: The clock enable returns to 1 exactly one cycle before the core reset falls. The clock enable is never 1 while the reset is high, except in that one cycle.
- R7: After the sequence ends, the enable bit reads 1 without any further write. While the sequence is running, the enable bit reads 0.
- R8: The context clear is high for exactly one cycle per sequence, in the first cycle of the reset, and only while the core reset is high.
- R9: A valid-key write that clears enable during a running sequence restarts the minimum-interval count.
- R10: A valid-key write with bit 1 = 1 changes only the stall bit. It neither starts nor disturbs a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Address-decoded write strobe |
| wr_data | input | 32 | Write data word |
| rd_data | output | 32 | Register read value |
| core_clk_en | output | 1 | Core clock enable |
| core_rst | output | 1 | Core reset, active high |
| dbg_stall | output | 1 | Stalls debug accesses to the core |
| ctx_clear | output | 1 | One-cycle clear of the protection context |

## Verification
The hardest case is a second disable write that lands partway through a running sequence, because the restart of the count can only be seen in when the reset is released. The bench issues the first clear, waits two cycles, then issues a second clear. It then checks that the reset stays high for a full new interval measured from the second write, and that no second context-clear pulse appears. The bench also issues a stall-only write in the middle of a sequence, which shows that such a write leaves the sequence running undisturbed.

// File: rtl/core_ctl_reg.sv
module core_ctl_reg #(
  parameter int DIS_CYCLES = 4,
  parameter logic [15:0] WR_KEY = 16'h05FA,
  parameter logic [15:0] RD_KEY = 16'hFA05
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        core_clk_en,
  output logic        core_rst,
  output logic        dbg_stall,
  output logic        ctx_clear
);
  localparam int CW = $clog2(DIS_CYCLES + 1) + 1;

  typedef enum logic [1:0] {RUN, HOLD, WAKE} phase_t;

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic          stall_q;
  logic          clr_q;

  wire key_ok  = wr_en && (wr_data[31:16] == WR_KEY);
  wire kill    = key_ok && !wr_data[1];
  wire en_bit  = (phase == RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= RUN;
      cnt     <= '0;
      stall_q <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      clr_q <= 1'b0;
      if (key_ok) stall_q <= wr_data[0];
      if (kill) begin
        if (phase == RUN) clr_q <= 1'b1;
        phase <= HOLD;
        cnt   <= CW'(DIS_CYCLES - 1);
      end else begin
        case (phase)
          HOLD: if (cnt == '0) phase <= WAKE;
                else cnt <= cnt - 1'b1;
          WAKE: phase <= RUN;
          default: phase <= RUN;
        endcase
      end
    end
  end

  assign core_rst    = (phase != RUN);
  assign core_clk_en = (phase != HOLD);
  assign dbg_stall   = stall_q;
  assign ctx_clear   = clr_q;
  assign rd_data     = {RD_KEY, 14'd0, en_bit, stall_q};

  a_r2_bad_key_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[31:16] != WR_KEY && phase == RUN) |=> $stable(dbg_stall) && !core_rst);
  a_r5_disable_resets: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> core_rst && !core_clk_en);
  a_r6_clk_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst) |-> $past(core_clk_en) && $past(core_rst));
  a_r8_clear_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_clear |-> core_rst && !core_clk_en);
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_clear |=> !ctx_clear);
  a_r4_stall_follows: assert property (@(posedge clk) disable iff (!rst_n)
    key_ok |=> dbg_stall == $past(wr_data[0]));
endmodule

// File: tb/core_ctl_reg_bench.sv
module core_ctl_reg_bench;
  localparam int DIS = 4;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic core_clk_en, core_rst, dbg_stall, ctx_clear;
  int total = 0, bad = 0;

  core_ctl_reg #(.DIS_CYCLES(DIS)) u_core_ctl_reg (.*);

  always #2 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = 0;
  endtask

  task automatic t_reset;
    chk("R1", rd_data, 32'hFA05_0002);
    chk("R1", {core_clk_en, core_rst, ctx_clear, dbg_stall}, 4'b1000);
  endtask

  task automatic t_badkey;
    wr(32'h05FB_0001); chk("R2", rd_data, 32'hFA05_0002);
    wr(32'h0000_0000); chk("R2", {rd_data[1], core_rst, core_clk_en}, 3'b101);
  endtask

  task automatic t_stall_and_read;
    wr(32'h05FA_FFFF); chk("R4", {dbg_stall, rd_data[0]}, 2'b11);
    chk("R3", rd_data, 32'hFA05_0003);
    wr(32'h05FA_0002); chk("R4", dbg_stall, 1'b0);
  endtask

  task automatic t_sequence;
    int hi = 0; int pulses = 0; bit order_ok = 1; bit prev_en = 0;
    @(negedge clk); wr_en = 1; wr_data = 32'h05FA_0000;
    @(negedge clk); wr_en = 0;
    chk("R5", {core_rst, core_clk_en}, 2'b10);
    chk("R7", rd_data[1], 1'b0);
    while (core_rst && hi < 50) begin
      hi++; pulses += ctx_clear;
      prev_en = core_clk_en;
      @(negedge clk);
    end
    if (!prev_en) order_ok = 0;
    chk("R5", hi >= DIS + 1, 1);
    chk("R6", order_ok, 1);
    chk("R8", pulses, 1);
    chk("R7", rd_data[1], 1'b1);
  endtask

  task automatic t_restart;
    int hi = 0; int pulses = 0;
    wr(32'h05FA_0000);
    hi = 1; pulses = 1;
    @(negedge clk); hi++;
    wr_en = 1; wr_data = 32'h05FA_0000;
    @(negedge clk); wr_en = 0; hi = 0;
    while (core_rst && hi < 50) begin hi++; pulses += ctx_clear; @(negedge clk); end
    chk("R9", hi, DIS + 1);
    chk("R8", pulses, 1);
  endtask

  task automatic t_stall_mid;
    int hi = 0;
    wr(32'h05FA_0000); hi = 1;
    wr(32'h05FA_0003); hi++;
    chk("R10", {dbg_stall, core_rst, rd_data[1]}, 3'b110);
    while (core_rst && hi < 50) begin hi++; @(negedge clk); end
    chk("R10", hi, DIS + 1);
    chk("R10", rd_data, 32'hFA05_0003);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_badkey; t_stall_and_read; t_sequence; t_restart; t_stall_mid;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #20000;
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule